// File: doc/BRIEF.md
# Edge-Capture Interrupt Register Block

This block gathers edges from a set of internal event lines and turns them into one active-high interrupt request. Two mask registers pick the edges that count for each line. One mask arms rising edges and the other arms falling edges, and a line may be armed in either direction or in both. An armed edge sets that line's bit in a sticky status register. The interrupt output is the OR of all status bits.

The event lines are plain wires from inside the chip. Examples are an end-of-conversion strobe from the converter (line 11) and the comparator level of the X+ touch plate (line 12); the remaining lines are spares. Each line is brought into the clock domain through a two-flop synchroniser before its edges are found.

Software reaches the block through a 16-bit register port with a 7-bit address. The status register and its clear control share one address. Software clears a bit by writing it as 1 and then writing 0 to the same address. Pen-touch detection is armed by setting bit 12 in the falling-edge mask alone. Writing 0 to that mask stops new captures.

Top module: `edge_irq_capture`

## Requirements
- R1: After reset, both masks, the status register and `irq_out` are 0.
- R2: A write to address 0x5E sets the rising-edge mask and a write to 0x60 sets the falling-edge mask. A read of either address returns the value last written. Mask bit n controls event line `evt_in[n]`.
- R3: A 0-to-1 change on `evt_in[n]` with rising-mask bit n set makes status bit n read 1 after the third rising clock edge following the change, and not earlier.
- R4: A 1-to-0 change on `evt_in[n]` with falling-mask bit n set makes status bit n read 1 after the third rising clock edge following the change.
- R5: An edge in a direction whose mask bit is 0 leaves the status bit at 0. A line that holds a steady level sets nothing.
- R6: A status bit stays at 1 after its line returns to the old level, until software clears it.
- R7: A write to 0x62 clears, at that clock edge, every status bit written as 1. While the last value written to 0x62 holds a bit at 1, edges on that bit are dropped. Edges are captured again once 0 has been written. Bits written as 0 are left alone.
- R8: Writing 0xFFFF and then 0x0000 to 0x62 clears all pending bits and leaves every line able to capture again.
- R9: `irq_out` is 1 exactly when at least one status bit is 1.
- R10: A read of 0x62 returns the live status bits. A read of any address other than 0x5E, 0x60 and 0x62 returns 0, and a write to such an address changes nothing.
- R11: With only bit 12 set in the falling-edge mask, a rising edge on line 12 sets nothing and a falling edge sets status bit 12. After 0 is written to the falling-edge mask, a further falling edge on line 12 sets nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 7 | Register address for reads and writes |
| reg_we | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| evt_in | input | 16 | Asynchronous event lines |
| irq_out | output | 1 | Active-high interrupt request |

## Verification
The bench sweeps every event line in both directions, with only that line's bit set in one mask at a time. A design that swapped the two masks, or that decoded the wrong line, would set the wrong status bit. The latency check looks two and three edges after a change; an extra or missing synchroniser stage shows up there. The clear sequence is driven while the clear bit is still 1. A design that let edges through during this hold window, or that cleared neighbouring bits, would leave stale or missing status. Unmapped addresses are written and then read back. A loose address decoder would corrupt a mask or return non-zero data.

// File: rtl/edge_irq_capture_pkg.sv
package edge_irq_capture_pkg;

  function automatic logic [15:0] edge_hits(
    input logic [15:0] cur,
    input logic [15:0] prev,
    input logic [15:0] rise_mask,
    input logic [15:0] fall_mask
  );
    return ((cur & ~prev) & rise_mask) | ((~cur & prev) & fall_mask);
  endfunction

  function automatic logic [15:0] status_after(
    input logic [15:0] status,
    input logic [15:0] hits,
    input logic [15:0] clear_bits
  );
    return (status | hits) & ~clear_bits;
  endfunction

endpackage

// File: rtl/edge_irq_sync.sv
module edge_irq_sync #(
  parameter int W = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] stg [STAGES];
  logic [W-1:0] prev_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[s] <= '0;
          else        stg[s] <= async_in;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[s] <= '0;
          else        stg[s] <= stg[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= '0;
    else        prev_q <= stg[STAGES-1];

  assign cur_o  = stg[STAGES-1];
  assign prev_o = prev_q;
endmodule

// File: rtl/edge_irq_status.sv
module edge_irq_status
  import edge_irq_capture_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] cur,
  input  logic [15:0] prev,
  input  logic [15:0] rise_mask,
  input  logic [15:0] fall_mask,
  input  logic        clr_wr,
  input  logic [15:0] clr_wdata,
  output logic [15:0] status_o,
  output logic        irq_o
);
  logic [15:0] status_q;
  logic [15:0] clr_q;
  logic [15:0] clr_now;
  logic [15:0] hit_vec;

  assign hit_vec = edge_hits(cur, prev, rise_mask, fall_mask);
  assign clr_now = clr_wr ? clr_wdata : clr_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      status_q <= '0;
      clr_q    <= '0;
    end else begin
      status_q <= status_after(status_q, hit_vec, clr_now);
      clr_q    <= clr_now;
    end

  assign status_o = status_q;
  assign irq_o    = |status_q;

  // R5: a status bit only rises after an armed edge on its line
  a_r5_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(hit_vec)) == 16'h0));

  // R6: a set bit only falls when a clear is applied to it
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(status_q) & ~status_q & ~$past(clr_now)) == 16'h0));

  // R7: while the clear value holds a bit at 1, that status bit is 0
  a_r7_clear_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q & clr_q) == 16'h0);

  // R9: the request can only go high after a capture
  a_r9_irq_rise_needs_capture: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(|hit_vec));
endmodule

// File: rtl/edge_irq_capture.sv
module edge_irq_capture #(
  parameter int          ADDR_W      = 7,
  parameter int          SYNC_STAGES = 2,
  parameter logic [6:0]  ADDR_RISE   = 7'h5E,
  parameter logic [6:0]  ADDR_FALL   = 7'h60,
  parameter logic [6:0]  ADDR_STAT   = 7'h62
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  input  logic [15:0]       evt_in,
  output logic              irq_out
);
  logic [15:0] rise_mask_q, fall_mask_q;
  logic [15:0] cur_s, prev_s, status_s;
  logic        sel_rise, sel_fall, sel_stat;

  assign sel_rise = (reg_addr == ADDR_RISE);
  assign sel_fall = (reg_addr == ADDR_FALL);
  assign sel_stat = (reg_addr == ADDR_STAT);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rise_mask_q <= '0;
      fall_mask_q <= '0;
    end else if (reg_we) begin
      if (sel_rise) rise_mask_q <= reg_wdata;
      if (sel_fall) fall_mask_q <= reg_wdata;
    end

  edge_irq_sync #(.W(16), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(evt_in),
    .cur_o(cur_s), .prev_o(prev_s)
  );

  edge_irq_status u_stat (
    .clk(clk), .rst_n(rst_n), .cur(cur_s), .prev(prev_s),
    .rise_mask(rise_mask_q), .fall_mask(fall_mask_q),
    .clr_wr(reg_we && sel_stat), .clr_wdata(reg_wdata),
    .status_o(status_s), .irq_o(irq_out)
  );

  always_comb begin
    reg_rdata = '0;
    if (sel_rise)      reg_rdata = rise_mask_q;
    else if (sel_fall) reg_rdata = fall_mask_q;
    else if (sel_stat) reg_rdata = status_s;
  end

  // R2: a mask write is visible in the mask on the next cycle
  a_r2_rise_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && sel_rise) |=> (rise_mask_q == $past(reg_wdata)));
  a_r2_fall_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && sel_fall) |=> (fall_mask_q == $past(reg_wdata)));

  // R10: writes elsewhere leave both masks alone
  a_r10_other_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !sel_rise && !sel_fall) |=> ($stable(rise_mask_q) && $stable(fall_mask_q)));
endmodule

// File: tb/sim_edge_irq_capture.sv
module sim_edge_irq_capture;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [15:0] evt_in = '0;
  logic        irq_out;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  localparam logic [6:0] A_RISE = 7'h5E, A_FALL = 7'h60, A_STAT = 7'h62;

  always #10 clk = ~clk;

  edge_irq_capture u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_in(evt_in), .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [15:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  // change lines at a falling edge, then wait three rising edges
  task automatic drive(input logic [15:0] v);
    evt_in = v;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear(input logic [15:0] m);
    wr(A_STAT, m); wr(A_STAT, 16'h0);
  endtask

  logic [15:0] r;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(A_RISE, r); chk("R1 rise mask", r, 16'h0);
    rd(A_FALL, r); chk("R1 fall mask", r, 16'h0);
    rd(A_STAT, r); chk("R1 status", r, 16'h0);
    chk("R1 irq", {15'h0, irq_out}, 16'h0);

    // R2 mask readback
    wr(A_RISE, 16'hA5C3); rd(A_RISE, r); chk("R2 rise readback", r, 16'hA5C3);
    wr(A_FALL, 16'h5A3C); rd(A_FALL, r); chk("R2 fall readback", r, 16'h5A3C);

    // R10 unmapped addresses
    wr(7'h10, 16'hFFFF); wr(7'h64, 16'h1234);
    rd(A_RISE, r); chk("R10 rise untouched", r, 16'hA5C3);
    rd(A_FALL, r); chk("R10 fall untouched", r, 16'h5A3C);
    rd(7'h10, r); chk("R10 unmapped read", r, 16'h0);
    rd(A_STAT, r); chk("R10 status untouched", r, 16'h0);

    // R3 latency: status appears after third rising edge
    wr(A_FALL, 16'h0); wr(A_RISE, 16'h0001);
    evt_in = 16'h0001;
    repeat (2) @(posedge clk); @(negedge clk);
    rd(A_STAT, r); chk("R3 not after two edges", r, 16'h0);
    @(posedge clk); @(negedge clk);
    rd(A_STAT, r); chk("R3 set after three edges", r, 16'h0001);
    chk("R9 irq high", {15'h0, irq_out}, 16'h1);
    drive(16'h0000);
    clear(16'h0001);
    chk("R9 irq low", {15'h0, irq_out}, 16'h0);

    // sweep every line in both directions
    for (int i = 0; i < 16; i++) begin
      logic [15:0] b;
      b = 16'h1 << i;
      wr(A_FALL, 16'h0); wr(A_RISE, b);
      drive(16'hFFFF);
      rd(A_STAT, r); chk("R3 rise sweep", r, b);
      drive(16'h0000);
      rd(A_STAT, r); chk("R6 sticky after return", r, b);
      clear(b);
      rd(A_STAT, r); chk("R7 cleared", r, 16'h0);
      wr(A_RISE, 16'h0); wr(A_FALL, b);
      drive(16'hFFFF);
      rd(A_STAT, r); chk("R5 rise unarmed", r, 16'h0);
      drive(16'h0000);
      rd(A_STAT, r); chk("R4 fall sweep", r, b);
      clear(16'hFFFF);
      rd(A_STAT, r); chk("R8 clear all", r, 16'h0);
    end

    // R5 steady level sets nothing
    wr(A_RISE, 16'hFFFF); wr(A_FALL, 16'hFFFF);
    repeat (5) @(negedge clk);
    rd(A_STAT, r); chk("R5 steady low", r, 16'h0);

    // R7 hold window and neighbour bits
    drive(16'h0028);
    rd(A_STAT, r); chk("R7 setup", r, 16'h0028);
    wr(A_STAT, 16'h0008);
    rd(A_STAT, r); chk("R7 only bit 3 cleared", r, 16'h0020);
    drive(16'h0020);
    rd(A_STAT, r); chk("R7 edge dropped while held", r, 16'h0020);
    wr(A_STAT, 16'h0000);
    rd(A_STAT, r); chk("R7 still clear after release", r, 16'h0020);
    drive(16'h0028);
    rd(A_STAT, r); chk("R7 captures after release", r, 16'h0028);
    clear(16'hFFFF);
    drive(16'h0000);
    clear(16'hFFFF);
    rd(A_STAT, r); chk("R8 all clear", r, 16'h0);

    // R11 touch arming on line 12
    wr(A_RISE, 16'h0); wr(A_FALL, 16'h1000);
    drive(16'h1000);
    rd(A_STAT, r); chk("R11 rise ignored", r, 16'h0);
    drive(16'h0000);
    rd(A_STAT, r); chk("R11 fall captured", r, 16'h1000);
    clear(16'h1000);
    wr(A_FALL, 16'h0);
    drive(16'h1000); drive(16'h0000);
    rd(A_STAT, r); chk("R11 disarmed", r, 16'h0);
    chk("R9 irq idle", {15'h0, irq_out}, 16'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule